// File: doc/BRIEF.md
# CPU Hotplug Event Register Controller

This block keeps track of hot-add and hot-remove events for a fixed set of processor slots and presents them to software through a small window of three 32-bit words. A platform port lets the surrounding system announce that a slot has been plugged or that its removal has been requested. Software answers through the register window. It picks a slot with a selector, reads that slot's status byte and acknowledges events by writing a control byte. It asks for ejection through the same byte, and it uses a command byte to find the next slot that needs attention. A command/data indirection also lets software hand two 32-bit report words (an event code and a status code) to the platform, which receives them on a one-cycle report strobe.

After reset the block is in a legacy mode. In that mode the window is a read-only presence bitmap with one bit per slot. Software leaves that mode for good by writing zero to the first word with all four byte lanes. An event interrupt line stays high while any slot holds an unacknowledged insert or remove event. An eject pulse tells the platform when a slot has been switched off.

Top module: `cpu_hotplug_ctl`

## Requirements
- R1: After reset the block is in legacy mode, every slot is disabled with no pending event, the selector and command are 0, and eventIrq, ejectDone and reportStrobe are low.
- R2: In legacy mode, a read of word w (regWordAddr) returns the presence bits of slots 32w..32w+31, with bit b standing for slot 32w+b. A write of 0x00000000 to word 0 with regBe=1111 switches to register mode, which is never left. All other legacy-mode writes are ignored. In register mode, word 0 reads 0.
- R3: A plug request for an in-range slot sets that slot's enabled and insert-event flags, and eventIrq is high from the next cycle on.
- R4: In register mode, a read of word 1 returns the selected slot's status: bit0 is enabled, bit1 is insert pending, bit2 is remove pending, and bits 31:3 are 0.
- R5: A control write (word 1, regBe=0001) clears the selected slot's insert event if bit1 is 1 and its remove event if bit2 is 1. Bit0 and bits 7:4 have no effect.
- R6: In register mode, an unplug request sets the remove-event flag of an enabled slot and leaves it enabled. An unplug request has no effect in legacy mode or on a disabled slot.
- R7: A control write with bit3=1 to an enabled slot clears its enabled and insert flags and leaves the remove flag as it was. In the cycle after the write, ejectDone is high for exactly one cycle and ejectSlot carries the slot number.
- R8: eventIrq is high while any slot has an insert or remove event pending, and it falls once the last one is cleared.
- R9: Writing command 0 (word 1, regBe=0010, value in bits 15:8) loads the selector with the first slot that has a pending event. The search starts at selector+1 and wraps, so the current slot is examined last. When the selector is out of range, the search starts at slot 0. When no slot has a pending event, the selector is left unchanged.
- R10: A read of word 2 returns the selector while the command is 0 and 0xFFFFFFFF under any other command value.
- R11: A data write (word 2, regBe=1111) under command 1 stores the event word. Under command 2 it stores the status word, and in the next cycle reportStrobe is high for one cycle with reportEvent and reportStatus holding both words. Under any other command a data write is ignored.
- R12: While the selector is NUM_SLOTS or above, control writes have no effect and word 1 reads 0.
- R13: A write whose byte strobes differ from the ones stated for its register (selector 1111, control 0001, command 0010, data 1111) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regWordAddr | input | 2 | Word index in the window (0 selector, 1 status/control/command, 2 data) |
| regBe | input | 4 | Byte-lane enables of the write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regWordAddr (combinational) |
| plugReq | input | 1 | Platform hot-add request for plugSlot |
| unplugReq | input | 1 | Platform hot-remove request for plugSlot |
| plugSlot | input | SLOT_W | Slot targeted by the platform request |
| eventIrq | output | 1 | Event interrupt, high while any event is pending |
| ejectDone | output | 1 | One-cycle pulse when a slot is switched off |
| ejectSlot | output | SLOT_W | Slot that was switched off |
| reportStrobe | output | 1 | One-cycle pulse after a status-word write |
| reportEvent | output | 32 | Last stored event word |
| reportStatus | output | 32 | Last stored status word |

## Verification
The bench plugs slots in several patterns and then runs the pending-event search against each of them. With two pending slots, the pattern shows whether the search starts after the selector. With the pending slot below the selector, it shows whether the search wraps. When the only pending slot is the selected one, it shows whether the current slot is examined last. With nothing pending, it shows whether the selector is left alone. Writes with mismatched byte strobes and out-of-range selectors are interleaved with legal ones to separate real decoding from lane-blind decoding. Legacy-mode unplugs and non-zero switch writes show that the mode boundary is kept.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

  localparam int WORD_W = 32;

  // word indices inside the register window
  localparam logic [1:0] WORD_SEL  = 2'd0;
  localparam logic [1:0] WORD_CTL  = 2'd1;
  localparam logic [1:0] WORD_DATA = 2'd2;

  // command values
  localparam logic [7:0] CMD_SCAN   = 8'd0;
  localparam logic [7:0] CMD_EVTREP = 8'd1;
  localparam logic [7:0] CMD_STSREP = 8'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic selLoad;   // selector write
    logic ctlLoad;   // control byte write
    logic scanGo;    // command 0 written: search for a pending slot
    logic evtLoad;   // data write under command 1
    logic stsLoad;   // data write under command 2
  } hpStrobe_t;

endpackage

// File: rtl/cpuhp_scan.sv
module cpuhp_scan #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] pending,
  input  logic [31:0]          curSel,
  output logic                 found,
  output logic [SLOT_W-1:0]    pick
);

  int unsigned base;
  int unsigned idx;

  // search starts one past the current slot and wraps; current slot last
  always_comb begin
    base  = (curSel < 32'(NUM_SLOTS)) ? int'(curSel) : NUM_SLOTS - 1;
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int k = 1; k <= NUM_SLOTS; k++) begin
      idx = base + k;
      if (idx >= NUM_SLOTS) idx = idx - NUM_SLOTS;
      if (!found && pending[idx]) begin
        found = 1'b1;
        pick  = SLOT_W'(idx);
      end
    end
  end

endmodule

// File: rtl/cpuhp_ctrl.sv
module cpuhp_ctrl
  import cpuhp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regWordAddr,
  input  logic [3:0]  regBe,
  input  logic [31:0] regWdata,
  output hpStrobe_t   str,
  output logic        legacyMode,
  output logic [7:0]  cmdSel
);

  logic selHit, ctlHit, cmdHit, dataHit, leaveLegacy;

  // strict byte-lane decode per register
  assign selHit  = regWr && regWordAddr == WORD_SEL  && regBe == 4'b1111;
  assign ctlHit  = regWr && regWordAddr == WORD_CTL  && regBe == 4'b0001;
  assign cmdHit  = regWr && regWordAddr == WORD_CTL  && regBe == 4'b0010;
  assign dataHit = regWr && regWordAddr == WORD_DATA && regBe == 4'b1111;

  assign leaveLegacy = legacyMode && selHit && regWdata == 32'h0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      legacyMode <= 1'b1;
      cmdSel     <= CMD_SCAN;
    end else begin
      if (leaveLegacy) legacyMode <= 1'b0;
      if (!legacyMode && cmdHit) cmdSel <= regWdata[15:8];
    end
  end

  always_comb begin
    str         = '0;
    str.selLoad = !legacyMode && selHit;
    str.ctlLoad = !legacyMode && ctlHit;
    str.scanGo  = !legacyMode && cmdHit && regWdata[15:8] == CMD_SCAN;
    str.evtLoad = !legacyMode && dataHit && cmdSel == CMD_EVTREP;
    str.stsLoad = !legacyMode && dataHit && cmdSel == CMD_STSREP;
  end

  AST_LEGACY_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    !legacyMode |=> !legacyMode); // R2

  AST_CMD_LANE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regWordAddr == WORD_CTL && regBe == 4'b0010) |=> $stable(cmdSel)); // R13

endmodule

// File: rtl/cpuhp_datapath.sv
module cpuhp_datapath
  import cpuhp_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpStrobe_t         str,
  input  logic              legacyMode,
  input  logic [7:0]        cmdSel,
  input  logic [1:0]        regWordAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              plugReq,
  input  logic              unplugReq,
  input  logic [SLOT_W-1:0] plugSlot,
  output logic              eventIrq,
  output logic              ejectDone,
  output logic [SLOT_W-1:0] ejectSlot,
  output logic              reportStrobe,
  output logic [31:0]       reportEvent,
  output logic [31:0]       reportStatus
);

  logic [NUM_SLOTS-1:0] slotOn, insPend, remPend, ejectVec;
  logic [31:0]          selector;
  logic                 selInRange;
  logic [SLOT_W-1:0]    selIdx;
  logic                 scanFound;
  logic [SLOT_W-1:0]    scanPick;

  assign selInRange = selector < 32'(NUM_SLOTS);
  assign selIdx     = selector[SLOT_W-1:0];

  // per-slot flag state
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    logic selHit, addIt, remIt, clrIns, clrRem;
    assign selHit = selInRange && selector == 32'(i);
    assign addIt  = plugReq && plugSlot == SLOT_W'(i);
    assign remIt  = unplugReq && !legacyMode && plugSlot == SLOT_W'(i) && slotOn[i];
    assign clrIns = str.ctlLoad && selHit && regWdata[1];
    assign clrRem = str.ctlLoad && selHit && regWdata[2];
    assign ejectVec[i] = str.ctlLoad && selHit && regWdata[3] && slotOn[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotOn[i]  <= 1'b0;
        insPend[i] <= 1'b0;
        remPend[i] <= 1'b0;
      end else begin
        if (addIt)            slotOn[i] <= 1'b1;
        else if (ejectVec[i]) slotOn[i] <= 1'b0;

        if (addIt)                      insPend[i] <= 1'b1;
        else if (clrIns || ejectVec[i]) insPend[i] <= 1'b0;

        if (remIt)       remPend[i] <= 1'b1;
        else if (clrRem) remPend[i] <= 1'b0;
      end
    end
  end

  cpuhp_scan #(.NUM_SLOTS(NUM_SLOTS)) uScan (
    .pending (insPend | remPend),
    .curSel  (selector),
    .found   (scanFound),
    .pick    (scanPick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selector     <= '0;
      ejectDone    <= 1'b0;
      ejectSlot    <= '0;
      reportStrobe <= 1'b0;
      reportEvent  <= '0;
      reportStatus <= '0;
    end else begin
      if (str.selLoad)                 selector <= regWdata;
      else if (str.scanGo && scanFound) selector <= 32'(scanPick);
      ejectDone    <= |ejectVec;
      if (|ejectVec) ejectSlot <= selIdx;
      if (str.evtLoad) reportEvent <= regWdata;
      if (str.stsLoad) reportStatus <= regWdata;
      reportStrobe <= str.stsLoad;
    end
  end

  assign eventIrq = |(insPend | remPend);

  // read mux
  logic [127:0] padOn;
  logic [2:0]   selStatus;
  assign padOn     = 128'(slotOn);
  assign selStatus = selInRange ? {remPend[selIdx], insPend[selIdx], slotOn[selIdx]} : 3'b000;

  always_comb begin
    regRdata = '0;
    if (legacyMode) begin
      if (regWordAddr != 2'd3) regRdata = padOn[32*regWordAddr +: 32];
    end else begin
      unique case (regWordAddr)
        WORD_CTL:  regRdata = {29'b0, selStatus};
        WORD_DATA: regRdata = (cmdSel == CMD_SCAN) ? selector : 32'hFFFF_FFFF;
        default:   regRdata = '0;
      endcase
    end
  end

  AST_HOTADD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    plugReq && 32'(plugSlot) < 32'(NUM_SLOTS) |=> eventIrq); // R3

  AST_IRQ_HOLDS_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    eventIrq && !str.ctlLoad |=> eventIrq); // R8

  AST_SCAN_MISS_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    str.scanGo && !(|(insPend | remPend)) |=> $stable(selector)); // R9

  AST_OOR_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    str.ctlLoad && !selInRange && !plugReq && !unplugReq
      |=> $stable(slotOn) && $stable(insPend) && $stable(remPend)); // R12

  AST_REPORT_CARRIES_WORD: assert property (@(posedge clk) disable iff (!rstN)
    reportStrobe |-> reportStatus == $past(regWdata)); // R11

  AST_EJECT_SWITCHES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ejectDone && !$past(plugReq) |-> !slotOn[ejectSlot]); // R7

endmodule

// File: rtl/cpu_hotplug_ctl.sv
module cpu_hotplug_ctl
  import cpuhp_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regWordAddr,
  input  logic [3:0]        regBe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              plugReq,
  input  logic              unplugReq,
  input  logic [SLOT_W-1:0] plugSlot,
  output logic              eventIrq,
  output logic              ejectDone,
  output logic [SLOT_W-1:0] ejectSlot,
  output logic              reportStrobe,
  output logic [31:0]       reportEvent,
  output logic [31:0]       reportStatus
);

  hpStrobe_t  str;
  logic       legacyMode;
  logic [7:0] cmdSel;

  cpuhp_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWr       (regWr),
    .regWordAddr (regWordAddr),
    .regBe       (regBe),
    .regWdata    (regWdata),
    .str         (str),
    .legacyMode  (legacyMode),
    .cmdSel      (cmdSel)
  );

  cpuhp_datapath #(.NUM_SLOTS(NUM_SLOTS)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .str          (str),
    .legacyMode   (legacyMode),
    .cmdSel       (cmdSel),
    .regWordAddr  (regWordAddr),
    .regWdata     (regWdata),
    .regRdata     (regRdata),
    .plugReq      (plugReq),
    .unplugReq    (unplugReq),
    .plugSlot     (plugSlot),
    .eventIrq     (eventIrq),
    .ejectDone    (ejectDone),
    .ejectSlot    (ejectSlot),
    .reportStrobe (reportStrobe),
    .reportEvent  (reportEvent),
    .reportStatus (reportStatus)
  );

endmodule

// File: tb/tb_cpu_hotplug_ctl.sv
module tb_cpu_hotplug_ctl;

  localparam int NS = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWr = 1'b0;
  logic [1:0]    regWordAddr = '0;
  logic [3:0]    regBe = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic          plugReq = 1'b0, unplugReq = 1'b0;
  logic [SW-1:0] plugSlot = '0;
  logic          eventIrq, ejectDone, reportStrobe;
  logic [SW-1:0] ejectSlot;
  logic [31:0]   reportEvent, reportStatus;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cpu_hotplug_ctl #(.NUM_SLOTS(NS)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regWordAddr = w; regBe = be; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regBe = '0;
  endtask

  task automatic busRead(input logic [1:0] w, output logic [31:0] d);
    regWordAddr = w;
    #1;
    d = regRdata;
  endtask

  task automatic platform(input bit unplug, input logic [SW-1:0] s);
    @(negedge clk);
    plugReq = !unplug; unplugReq = unplug; plugSlot = s;
    @(negedge clk);
    plugReq = 1'b0; unplugReq = 1'b0;
  endtask

  // vector: op(2) word(2) be(4) data(32) exp(32) req(4)
  // op: 0 write, 1 read and compare, 2 plug slot data, 3 unplug slot data
  localparam int NV = 46;
  localparam logic [75:0] VEC [NV] = '{
    {2'd1, 2'd0, 4'h0, 32'h0,     32'h0,        4'd1},  // R1 legacy map empty
    {2'd2, 2'd0, 4'h0, 32'd3,     32'h0,        4'd3},
    {2'd2, 2'd0, 4'h0, 32'd5,     32'h0,        4'd3},
    {2'd1, 2'd0, 4'h0, 32'h0,     32'h28,       4'd2},  // R2 slots 3,5 present
    {2'd3, 2'd0, 4'h0, 32'd3,     32'h0,        4'd6},
    {2'd1, 2'd0, 4'h0, 32'h0,     32'h28,       4'd6},  // R6 legacy unplug ignored
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h0,        4'd2},  // R2 upper bitmap word
    {2'd0, 2'd0, 4'hF, 32'h1,     32'h0,        4'd2},
    {2'd1, 2'd0, 4'h0, 32'h0,     32'h28,       4'd2},  // R2 nonzero keeps legacy
    {2'd0, 2'd0, 4'h3, 32'h0,     32'h0,        4'd13},
    {2'd1, 2'd0, 4'h0, 32'h0,     32'h28,       4'd13}, // R13 partial lanes ignored
    {2'd0, 2'd0, 4'hF, 32'h0,     32'h0,        4'd2},
    {2'd1, 2'd0, 4'h0, 32'h0,     32'h0,        4'd2},  // R2 register mode
    {2'd1, 2'd2, 4'h0, 32'h0,     32'h0,        4'd10}, // R10 selector 0
    {2'd0, 2'd1, 4'h2, 32'h0,     32'h0,        4'd9},
    {2'd1, 2'd2, 4'h0, 32'h0,     32'd3,        4'd9},  // R9 finds 3
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h3,        4'd4},  // R4 enabled+insert
    {2'd0, 2'd1, 4'h1, 32'hF1,    32'h0,        4'd5},
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h3,        4'd5},  // R5 bits 0,7:4 ignored
    {2'd0, 2'd1, 4'hF, 32'h02,    32'h0,        4'd13},
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h3,        4'd13}, // R13 control lane check
    {2'd0, 2'd1, 4'h1, 32'h02,    32'h0,        4'd5},
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h1,        4'd5},  // R5 insert cleared
    {2'd0, 2'd1, 4'h2, 32'h0,     32'h0,        4'd9},
    {2'd1, 2'd2, 4'h0, 32'h0,     32'd5,        4'd9},  // R9 finds 5
    {2'd0, 2'd1, 4'h1, 32'h02,    32'h0,        4'd5},
    {2'd0, 2'd1, 4'h2, 32'h0,     32'h0,        4'd9},
    {2'd1, 2'd2, 4'h0, 32'h0,     32'd5,        4'd9},  // R9 miss keeps selector
    {2'd3, 2'd0, 4'h0, 32'd5,     32'h0,        4'd6},
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h5,        4'd6},  // R6 remove, still enabled
    {2'd0, 2'd1, 4'h1, 32'h08,    32'h0,        4'd7},
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h4,        4'd7},  // R7 off, remove kept
    {2'd0, 2'd1, 4'h1, 32'h04,    32'h0,        4'd5},
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h0,        4'd5},  // R5 remove cleared
    {2'd0, 2'd0, 4'hF, 32'd9,     32'h0,        4'd12},
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h0,        4'd12}, // R12 out of range reads 0
    {2'd0, 2'd1, 4'h1, 32'h08,    32'h0,        4'd12},
    {2'd1, 2'd2, 4'h0, 32'h0,     32'd9,        4'd10}, // R10 raw selector
    {2'd0, 2'd1, 4'h2, 32'h100,   32'h0,        4'd10},
    {2'd1, 2'd2, 4'h0, 32'h0,     32'hFFFFFFFF, 4'd10}, // R10 command 1
    {2'd0, 2'd1, 4'h2, 32'h700,   32'h0,        4'd10},
    {2'd1, 2'd2, 4'h0, 32'h0,     32'hFFFFFFFF, 4'd10}, // R10 command 7
    {2'd0, 2'd0, 4'hF, 32'd3,     32'h0,        4'd12},
    {2'd1, 2'd1, 4'h0, 32'h0,     32'h1,        4'd12}, // R12 eject was ignored
    {2'd0, 2'd1, 4'h2, 32'h0,     32'h0,        4'd9},
    {2'd1, 2'd2, 4'h0, 32'h0,     32'd3,        4'd9}   // R9 nothing pending
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    check("R1 irq", 32'(eventIrq), 0);
    check("R1 eject", 32'(ejectDone), 0);
    check("R1 report", 32'(reportStrobe), 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op; logic [1:0] w; logic [3:0] be;
      logic [31:0] d, e; logic [3:0] rq;
      {op, w, be, d, e, rq} = VEC[v];
      case (op)
        2'd0: busWrite(w, be, d);
        2'd1: begin
          busRead(w, rd);
          check($sformatf("R%0d vector %0d", rq, v), rd, e);
        end
        2'd2: platform(1'b0, d[SW-1:0]);
        default: platform(1'b1, d[SW-1:0]);
      endcase
    end

    // R8 no pending events now
    check("R8 idle irq", 32'(eventIrq), 0);
    platform(1'b0, 3'd1);
    check("R3 irq after plug", 32'(eventIrq), 1);
    platform(1'b0, 3'd6);
    busWrite(2'd0, 4'hF, 32'd6);
    busWrite(2'd1, 4'h2, 32'h0);
    busRead(2'd2, rd);
    check("R9 wrap from 6", rd, 32'd1);
    busWrite(2'd1, 4'h2, 32'h0);
    busRead(2'd2, rd);
    check("R9 next after 1", rd, 32'd6);
    busWrite(2'd0, 4'hF, 32'd1);
    busWrite(2'd1, 4'h1, 32'h02);
    check("R8 irq with one pending", 32'(eventIrq), 1);
    busWrite(2'd1, 4'h2, 32'h0);
    busRead(2'd2, rd);
    check("R9 sole pending found", rd, 32'd6);
    busWrite(2'd1, 4'h2, 32'h0);
    busRead(2'd2, rd);
    check("R9 current slot last", rd, 32'd6);
    busWrite(2'd1, 4'h1, 32'h02);
    check("R8 irq falls", 32'(eventIrq), 0);

    // R7 eject pulse
    busWrite(2'd1, 4'h1, 32'h08);
    check("R7 pulse", 32'(ejectDone), 1);
    check("R7 slot", 32'(ejectSlot), 32'd6);
    @(negedge clk);
    check("R7 single cycle", 32'(ejectDone), 0);
    platform(1'b1, 3'd6);
    busRead(2'd1, rd);
    check("R6 unplug of disabled slot", rd, 32'h0);

    // R11 reports
    busWrite(2'd1, 4'h2, 32'h100);
    busWrite(2'd2, 4'hF, 32'hA5A5_0001);
    check("R11 no strobe on event word", 32'(reportStrobe), 0);
    busWrite(2'd1, 4'h2, 32'h200);
    busWrite(2'd2, 4'h3, 32'h0000_0077);
    check("R13 data lanes", 32'(reportStrobe), 0);
    busWrite(2'd2, 4'hF, 32'h0000_0003);
    check("R11 strobe", 32'(reportStrobe), 1);
    check("R11 event word", reportEvent, 32'hA5A5_0001);
    check("R11 status word", reportStatus, 32'h0000_0003);
    @(negedge clk);
    check("R11 one cycle", 32'(reportStrobe), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule